// File: doc/BRIEF.md
# Punctured Rate-1/2 Convolutional Encoder

This block is the inner forward-error-correction encoder of a vehicular OFDM transmit chain. It sits between the outer block-code stage and the bit interleaver. Each accepted data bit is pushed through a six-stage shift register. Two parity bits are formed from it: bit A from the octal generator 171 and bit B from the octal generator 133, with constraint length 7. A puncturing stage then drops some of these bits so that the overall code rate is 1/2, 2/3 or 3/4.

Every accepted input bit produces exactly one output beat. A beat carries either two coded bits or one. The kept bits of a beat are placed earliest-first, starting at lane 0, so the serial coded stream is lane 0 followed by lane 1 when the beat is a pair. This lets the block take one input bit in every cycle at every rate.

Both streaming sides use valid/ready. An input bit is taken on a clock edge where `in_valid` and `in_ready` are both high. A beat leaves on an edge where `out_valid` and `out_ready` are both high. A two-entry output buffer decouples the two sides, so `in_ready` depends only on buffer occupancy and never on `out_ready` in the same cycle. While the consumer stalls, a presented beat stays frozen. Once the buffer is full, `in_ready` drops.

`frm_start` is a plain control strobe. It zeroes the shift register, returns the puncturing phase to its first position and latches `rate_sel`. If it coincides with an accepted bit, that bit is encoded as the first bit of the new frame.

Top module: `cc_punct_enc`

## Requirements
- R1: A = d ^ d-1 ^ d-2 ^ d-3 ^ d-6 (generator 171) and B = d ^ d-2 ^ d-3 ^ d-5 ^ d-6 (generator 133), where d-k is the bit accepted k bits earlier in the frame. Bits earlier than the frame start or reset count as 0.
- R2: At rate code 00 (rate 1/2), every beat has out_pair=1, with A on out_bits[0] and B on out_bits[1].
- R3: At rate code 01 (rate 2/3), the pattern repeats every 2 input bits: phase 0 gives the pair {A,B}, and phase 1 gives A alone. A single-bit beat has out_pair=0, the bit on out_bits[0] and out_bits[1]=0.
- R4: At rate code 10 (rate 3/4), the pattern repeats every 3 input bits: phase 0 gives the pair {A,B}, phase 1 gives A alone, and phase 2 gives B alone. Single-bit beats use the lane layout of R3.
- R5: rate_sel is latched only while frm_start is high and is ignored at all other times. Reset selects rate 1/2. Code 11 behaves as rate 1/2.
- R6: frm_start clears the shift register and the puncturing phase. A bit accepted in the same cycle is encoded as phase 0 with a zero history.
- R7: While out_valid=1 and out_ready=0, out_bits and out_pair hold stable. in_ready is 0 whenever the buffer holds two beats. No beat is lost or duplicated.
- R8: While out_ready stays high, in_ready stays high and one beat leaves per accepted bit.
- R9: After reset, out_valid=0 and in_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | Frame start: clear state and phase, latch rate |
| rate_sel | input | 2 | Rate code: 00 = 1/2, 01 = 2/3, 10 = 3/4, 11 = 1/2 |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Encoder can take a bit |
| in_bit | input | 1 | Data bit |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Consumer takes the beat |
| out_bits | output | 2 | Coded bits, lane 0 first in time |
| out_pair | output | 1 | 1 when both lanes carry a coded bit |

## Verification
A bit accepted at a clock edge produces its beat on the outputs just after that same edge when the buffer is empty. Under stall, the beat waits behind earlier beats in order. Both in_ready and out_valid are derived from registered occupancy, so they change only right after an edge.

The bench drives inputs at the falling edge and samples one time unit before the next rising edge. At that point it records the handshakes that the coming edge will complete. Each departing beat is compared against a reference queue built from R1 to R6, so the checks follow the actual departure cycle and not a fixed delay.

// File: rtl/cc_punct_pkg.sv
package cc_punct_pkg;

  typedef enum logic [1:0] {
    RATE_1_2  = 2'b00,
    RATE_2_3  = 2'b01,
    RATE_3_4  = 2'b10,
    RATE_RSVD = 2'b11
  } rate_e;

  localparam int unsigned PH_W = 2;

  typedef struct packed {
    logic       pair;
    logic [1:0] bits;
  } beat_t;

  function automatic logic [PH_W-1:0] rate_period(input rate_e r);
    case (r)
      RATE_2_3: rate_period = PH_W'(2);
      RATE_3_4: rate_period = PH_W'(3);
      default:  rate_period = PH_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/cc_gen_core.sv
module cc_gen_core #(
  parameter int unsigned    K  = 7,
  parameter logic [K-1:0]   GA = 7'o171,
  parameter logic [K-1:0]   GB = 7'o133
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic adv,
  input  logic din,
  output logic a,
  output logic b
);
  localparam int unsigned SW = K - 1;

  logic [SW-1:0] state_q;
  logic [SW-1:0] state_eff;
  logic [K-1:0]  win;
  logic [K-1:0]  tap_a;
  logic [K-1:0]  tap_b;

  // A frame start overrides history for a bit accepted in the same cycle.
  assign state_eff = clear ? '0 : state_q;
  assign win       = {state_eff, din};

  // Window index k is delay k; generator MSB weights delay 0.
  for (genvar k = 0; k < K; k++) begin : g_tap
    assign tap_a[k] = GA[K-1-k] & win[k];
    assign tap_b[k] = GB[K-1-k] & win[k];
  end

  assign a = ^tap_a;
  assign b = ^tap_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (adv) begin
      state_q <= {state_eff[SW-2:0], din};
    end else if (clear) begin
      state_q <= '0;
    end
  end

endmodule

// File: rtl/cc_punct_sel.sv
module cc_punct_sel
  import cc_punct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic [1:0] rate_in,
  input  logic       adv,
  output logic       keep_a,
  output logic       keep_b
);
  rate_e           rate_q;
  rate_e           rate_eff;
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_eff;
  logic [PH_W-1:0] phase_nxt;
  logic [PH_W-1:0] period;

  assign rate_eff  = clear ? rate_e'(rate_in) : rate_q;
  assign phase_eff = clear ? '0 : phase_q;
  assign period    = rate_period(rate_eff);
  assign phase_nxt = (phase_eff + 1'b1 == period) ? '0 : phase_eff + 1'b1;

  always_comb begin
    keep_a = 1'b1;
    keep_b = 1'b1;
    case (rate_eff)
      RATE_2_3: begin
        if (phase_eff == PH_W'(1)) keep_b = 1'b0;
      end
      RATE_3_4: begin
        if (phase_eff == PH_W'(1)) keep_b = 1'b0;
        if (phase_eff == PH_W'(2)) keep_a = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= RATE_1_2;
      phase_q <= '0;
    end else begin
      if (clear) rate_q <= rate_e'(rate_in);
      if (adv) phase_q <= phase_nxt;
      else if (clear) phase_q <= '0;
    end
  end

endmodule

// File: rtl/cc_beat_fifo.sv
module cc_beat_fifo #(
  parameter int unsigned W     = 3,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] cnt;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/cc_punct_enc.sv
module cc_punct_enc
  import cc_punct_pkg::*;
#(
  parameter int unsigned  K         = 7,
  parameter logic [K-1:0] GEN_A     = 7'o171,
  parameter logic [K-1:0] GEN_B     = 7'o133,
  parameter int unsigned  BUF_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_start,
  input  logic [1:0] rate_sel,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_bit,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [1:0] out_bits,
  output logic       out_pair
);
  logic  accept;
  logic  pop;
  logic  full;
  logic  empty;
  logic  bit_a;
  logic  bit_b;
  logic  keep_a;
  logic  keep_b;
  beat_t beat_in;
  beat_t beat_out;

  assign in_ready  = !full;
  assign accept    = in_valid && in_ready;
  assign out_valid = !empty;
  assign pop       = out_valid && out_ready;

  cc_gen_core #(.K(K), .GA(GEN_A), .GB(GEN_B)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (frm_start),
    .adv   (accept),
    .din   (in_bit),
    .a     (bit_a),
    .b     (bit_b)
  );

  cc_punct_sel u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (frm_start),
    .rate_in (rate_sel),
    .adv     (accept),
    .keep_a  (keep_a),
    .keep_b  (keep_b)
  );

  // Pack kept bits earliest-first into lane 0.
  always_comb begin
    beat_in.pair = keep_a && keep_b;
    if (keep_a && keep_b) beat_in.bits = {bit_b, bit_a};
    else if (keep_a)      beat_in.bits = {1'b0, bit_a};
    else                  beat_in.bits = {1'b0, bit_b};
  end

  cc_beat_fifo #(.W($bits(beat_t)), .DEPTH(BUF_DEPTH)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept),
    .wdata (beat_in),
    .full  (full),
    .pop   (pop),
    .rdata (beat_out),
    .empty (empty)
  );

  assign out_bits = beat_out.bits;
  assign out_pair = beat_out.pair;

endmodule

// File: rtl/cc_punct_enc_chk.sv
module cc_punct_enc_chk #(
  parameter int unsigned DEPTH = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_bits,
  input logic       out_pair
);
  int occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= 0;
    else occ <= occ + int'(in_valid && in_ready) - int'(out_valid && out_ready);
  end

  // R7: a stalled beat holds
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bits) && $stable(out_pair));

  // R7: no push past capacity
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    occ >= DEPTH |-> !in_ready);

  // R7: a beat is presented exactly when one is owed
  p_valid_owed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != 0) == out_valid);

  // R3, R4: single-bit beats keep lane 1 at zero
  p_single_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_pair |-> !out_bits[1]);

  // R8: an empty buffer always accepts
  p_empty_accepts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R9: state right after reset release
  p_reset_state_r9: assert property (@(posedge clk)
    $rose(rst_n) |-> in_ready && !out_valid);

endmodule

bind cc_punct_enc cc_punct_enc_chk #(.DEPTH(BUF_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bits  (out_bits),
  .out_pair  (out_pair)
);

// File: tb/tb_cc_punct_enc.sv
module tb_cc_punct_enc;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frm_start = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       out_ready = 1'b0;
  logic       in_ready;
  logic       out_valid;
  logic [1:0] out_bits;
  logic       out_pair;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0]  m_state;
  int          m_phase;
  int          m_period;
  logic [1:0]  e_bits [1024];
  logic        e_pair [1024];
  int          e_wr;
  int          e_rd;
  logic [15:0] lfsr = 16'hACE1;
  int          stall_lows;

  always #(PERIOD/2) clk = ~clk;

  cc_punct_enc dut (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .rate_sel(rate_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_bits(out_bits),
    .out_pair(out_pair)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // One cycle: drive at the falling edge, sample just before the rising edge.
  task automatic step(input logic v, input logic d, input logic fs,
                      input logic [1:0] rs, input logic ordy, input string tag);
    logic a, b;
    @(negedge clk);
    in_valid = v; in_bit = d; frm_start = fs; rate_sel = rs; out_ready = ordy;
    #(PERIOD/2 - 1);
    if (out_valid && out_ready) begin
      if (e_rd == e_wr) begin
        check(1'b0, tag, "unexpected beat", 1, 0);
      end else begin
        check(out_bits == e_bits[e_rd % 1024] && out_pair == e_pair[e_rd % 1024],
              tag, "beat {pair,bits}", {out_pair, out_bits},
              {e_pair[e_rd % 1024], e_bits[e_rd % 1024]});
        e_rd++;
      end
    end
    if (fs) begin
      m_state = '0;
      m_phase = 0;
      m_period = (rs == 2'b01) ? 2 : (rs == 2'b10) ? 3 : 1;
    end
    if (v && in_ready) begin
      a = d ^ m_state[0] ^ m_state[1] ^ m_state[2] ^ m_state[5];
      b = d ^ m_state[1] ^ m_state[2] ^ m_state[4] ^ m_state[5];
      if (m_phase == 0)      begin e_bits[e_wr % 1024] = {b, a}; e_pair[e_wr % 1024] = 1'b1; end
      else if (m_phase == 1) begin e_bits[e_wr % 1024] = {1'b0, a}; e_pair[e_wr % 1024] = 1'b0; end
      else                   begin e_bits[e_wr % 1024] = {1'b0, b}; e_pair[e_wr % 1024] = 1'b0; end
      e_wr++;
      m_state = {m_state[4:0], d};
      m_phase = (m_phase + 1 == m_period) ? 0 : m_phase + 1;
    end
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b0, 2'b00, 1'b1, tag);
    check(e_rd == e_wr, tag, "beats still owed", e_wr - e_rd, 0);
    check(out_valid == 1'b0, tag, "out_valid after drain", out_valid, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    m_state = '0; m_phase = 0; m_period = 1; e_wr = 0; e_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
  endtask

  // Reset default rate is 1/2 with no frame start; also a known impulse.
  task automatic t_impulse_half();
    step(1'b1, 1'b1, 1'b0, 2'b10, 1'b1, "R1");
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, 2'b10, 1'b1, "R1");
    drain("R1");
  endtask

  task automatic t_half_stream();
    int lows = 0;
    step(1'b1, next_bit(), 1'b1, 2'b00, 1'b1, "R2");
    for (int i = 0; i < 40; i++) begin
      step(1'b1, next_bit(), 1'b0, 2'b00, 1'b1, "R2");
      if (!in_ready) lows++;
    end
    check(lows == 0, "R8", "in_ready low cycles at full rate", lows, 0);
    drain("R2");
  endtask

  task automatic t_two_thirds();
    step(1'b1, next_bit(), 1'b1, 2'b01, 1'b1, "R3");
    for (int i = 0; i < 31; i++) step(1'b1, next_bit(), 1'b0, 2'b01, 1'b1, "R3");
    drain("R3");
  endtask

  task automatic t_three_quarters();
    step(1'b1, next_bit(), 1'b1, 2'b10, 1'b1, "R4");
    for (int i = 0; i < 35; i++) step(1'b1, next_bit(), 1'b0, 2'b10, 1'b1, "R4");
    drain("R4");
  endtask

  // rate_sel moves mid-frame without frm_start: it must not matter.
  task automatic t_rate_latch();
    step(1'b1, next_bit(), 1'b1, 2'b10, 1'b1, "R5");
    for (int i = 0; i < 20; i++) step(1'b1, next_bit(), 1'b0, 2'b00, 1'b1, "R5");
    step(1'b1, next_bit(), 1'b1, 2'b11, 1'b1, "R5");
    for (int i = 0; i < 12; i++) step(1'b1, next_bit(), 1'b0, 2'b01, 1'b1, "R5");
    drain("R5");
  endtask

  // Restart mid-frame and mid-pattern; the coincident bit starts the frame.
  task automatic t_restart();
    step(1'b1, 1'b1, 1'b1, 2'b10, 1'b1, "R6");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, 2'b10, 1'b1, "R6");
    step(1'b1, 1'b1, 1'b1, 2'b01, 1'b1, "R6");
    for (int i = 0; i < 5; i++) step(1'b1, next_bit(), 1'b0, 2'b01, 1'b1, "R6");
    step(1'b0, 1'b0, 1'b1, 2'b10, 1'b1, "R6");
    for (int i = 0; i < 9; i++) step(1'b1, next_bit(), 1'b0, 2'b10, 1'b1, "R6");
    drain("R6");
  endtask

  task automatic t_backpressure();
    step(1'b1, next_bit(), 1'b1, 2'b10, 1'b0, "R7");
    for (int i = 0; i < 3; i++) step(1'b1, next_bit(), 1'b0, 2'b10, 1'b0, "R7");
    check(in_ready == 1'b0, "R7", "in_ready with full buffer", in_ready, 0);
    check(out_valid == 1'b1, "R7", "out_valid with full buffer", out_valid, 1);
    for (int i = 0; i < 60; i++)
      step(1'b1, next_bit(), 1'b0, 2'b10, (i % 3) != 0 && (i % 7) != 1, "R7");
    drain("R7");
  endtask

  initial begin
    t_reset();
    t_impulse_half();
    t_half_stream();
    t_two_thirds();
    t_three_quarters();
    t_rate_latch();
    t_restart();
    t_backpressure();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule